// File: doc/BRIEF.md
# Hit Time Window Offset Filter

This block sits after a multi-channel time-to-digital converter. The converter measures each hit backwards from a common stop. The block receives one raw hit per cycle: a time stamp in 0.5 ns ticks, an edge flag and a channel number. It rebases each time onto a programmable offset and rejects hits that fall beyond the maximum time range. It then quantises the rebased time to the selected resolution and packs it into a data word that is qualified by a valid strobe.

A hit that lands between the stop and the lower window bound (earlier than the offset) is not thrown away. It still produces a word, with time code zero, and so still uses storage downstream. Each channel also has a hit counter. Once the counter reaches the programmed limit, further hits on that channel are discarded until the next event-start pulse.

The offset and the range are held in two registers written through a small write port, in nanoseconds. Both must be multiples of 8 ns. A misaligned write is rounded down and raises a sticky error flag. Resolution, edge mode and the hit limit are static inputs.

Top module: `hit_window_filter`

## Requirements
- R1: After reset, out_vld and cfg_err are low, and the offset and range registers both hold 0 ns.
- R2: An accepted hit appears on out_vld exactly one clock after its hit_vld cycle, with out_chan equal to the hit's channel. Dropped hits produce no output.
- R3: The time code is floor((raw_ticks - 2*offset_ns) / 2^cfg_res), where one tick is 0.5 ns. cfg_res = 0, 1, 2, 3 selects an LSB of 0.5, 1, 2 or 4 ns.
- R4: A hit is kept only when raw_ticks < 2*(range_ns + 8), so the last kept time is range + 7.5 ns.
- R5: In leading-edge-only mode the code span is 1024 values; in both-edges mode it is 512. A hit whose rebased time needs a code at or above the span is dropped.
- R6: A hit with raw time below the offset is kept, with time code 0.
- R7: The word format depends on the mode. With cfg_both=0, out_word[9:0] is the 10-bit code. With cfg_both=1, out_word[8:0] is the 9-bit code and out_word[9] is the edge flag (0 leading, 1 trailing).
- R8: With cfg_both=0, hits with hit_edge=1 (trailing) are dropped.
- R9: Register writes use cfg_wr, with cfg_sel=0 for the offset and cfg_sel=1 for the range. The stored value is cfg_wdata with bits [2:0] cleared. If those bits were nonzero, cfg_err is set and stays set until reset.
- R10: Each channel accepts at most cfg_max_hits hits per event, and later hits on that channel are dropped. evt_start clears all counters. A hit in the evt_start cycle counts as the first hit of the new event.
- R11: With cfg_max_hits = 0, every hit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects offset, 1 selects range |
| cfg_wdata | input | 12 | Write value in ns |
| cfg_res | input | 2 | Resolution select (0.5/1/2/4 ns) |
| cfg_both | input | 1 | 1 = both edges, 0 = leading only |
| cfg_max_hits | input | 5 | Hit limit per channel per event |
| cfg_err | output | 1 | Sticky misaligned-write flag |
| evt_start | input | 1 | Event start, clears hit counters |
| hit_vld | input | 1 | Raw hit strobe |
| hit_time | input | 14 | Raw time in 0.5 ns ticks |
| hit_edge | input | 1 | 0 leading, 1 trailing |
| hit_chan | input | 3 | Channel number |
| out_vld | output | 1 | Output word valid |
| out_chan | output | 3 | Channel of output word |
| out_word | output | 10 | Data word |

## Verification
The hit-limit check assumes cfg_max_hits changes only while no event is in progress, that is, just before an evt_start pulse. The stimulus follows this: every limit change is immediately followed by a start pulse. The checks also assume cfg_res, cfg_both and the registers are not changed in the same cycle as a hit, so the bench drives configuration only during idle cycles. Inputs are driven on the falling edge, so each hit is seen by exactly one rising edge.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
  localparam int TW   = 14;  // raw time width in 0.5 ns ticks
  localparam int CFGW = 12;  // config width in ns
  localparam int CHW  = 3;   // channel index width
  localparam int LIMW = 5;   // hit limit width
  localparam int CW   = 10;  // data word width
  localparam int AW   = TW + 1;
  typedef enum logic [1:0] {
    RES_0P5 = 2'd0, RES_1P0 = 2'd1, RES_2P0 = 2'd2, RES_4P0 = 2'd3
  } res_e;
endpackage

// File: rtl/hwf_cfg.sv
module hwf_cfg
  import hwf_pkg::*;
#(
  parameter int W = CFGW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] offset_ns,
  output logic [W-1:0] range_ns,
  output logic         err
);
  logic [W-1:0] offset_d, range_d, aligned;
  logic         err_d;

  always_comb begin
    aligned  = {wdata[W-1:3], 3'b000};
    offset_d = offset_ns;
    range_d  = range_ns;
    err_d    = err;
    if (wr) begin
      if (sel) range_d  = aligned;
      else     offset_d = aligned;
      if (wdata[2:0] != 3'b000) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_ns <= '0;
      range_ns  <= '0;
      err       <= 1'b0;
    end else begin
      offset_ns <= offset_d;
      range_ns  <= range_d;
      err       <= err_d;
    end
  end
endmodule

// File: rtl/hwf_quant.sv
module hwf_quant
  import hwf_pkg::*;
(
  input  logic [TW-1:0]   raw,
  input  logic [CFGW-1:0] offset_ns,
  input  logic [CFGW-1:0] range_ns,
  input  res_e            res,
  input  logic            both,
  input  logic            edge_in,
  output logic            pass,
  output logic [CW-1:0]   word
);
  logic [AW-1:0] raw_w, off_t, lim_t, diff, span;
  logic [CW-1:0] code;
  logic          early, in_win, in_span, edge_ok;

  always_comb begin
    raw_w   = AW'(raw);
    off_t   = AW'({offset_ns, 1'b0});
    lim_t   = AW'({(CFGW + 1)'(range_ns) + (CFGW + 1)'(8), 1'b0});
    early   = raw_w < off_t;
    diff    = early ? '0 : raw_w - off_t;
    span    = (both ? AW'(512) : AW'(1024)) << res;
    in_win  = raw_w < lim_t;
    in_span = diff < span;
    edge_ok = both | ~edge_in;
    pass    = in_win & in_span & edge_ok;
    unique case (res)
      RES_0P5: code = diff[9:0];
      RES_1P0: code = diff[10:1];
      RES_2P0: code = diff[11:2];
      default: code = diff[12:3];
    endcase
    word = both ? {edge_in, code[8:0]} : code;
  end
endmodule

// File: rtl/hwf_limit.sv
module hwf_limit
  import hwf_pkg::*;
#(
  parameter int NCH_W = CHW,
  parameter int LW    = LIMW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  input  logic [NCH_W-1:0] chan,
  input  logic [LW-1:0]    max_hits,
  output logic             accept
);
  localparam int NCH = 1 << NCH_W;
  logic [LW-1:0] cnt_q [NCH];
  logic [LW-1:0] cnt_d [NCH];

  always_comb begin
    if (start) accept = hit & (max_hits != '0);
    else       accept = hit & (cnt_q[chan] < max_hits);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic mine;
    always_comb begin
      mine = accept & (chan == NCH_W'(c));
      if (start) cnt_d[c] = mine ? LW'(1) : '0;
      else       cnt_d[c] = cnt_q[c] + LW'(mine);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[c] <= '0;
      else        cnt_q[c] <= cnt_d[c];
    end
  end
endmodule

// File: rtl/hit_window_filter.sv
module hit_window_filter
  import hwf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic [1:0]      cfg_res,
  input  logic            cfg_both,
  input  logic [LIMW-1:0] cfg_max_hits,
  output logic            cfg_err,
  input  logic            evt_start,
  input  logic            hit_vld,
  input  logic [TW-1:0]   hit_time,
  input  logic            hit_edge,
  input  logic [CHW-1:0]  hit_chan,
  output logic            out_vld,
  output logic [CHW-1:0]  out_chan,
  output logic [CW-1:0]   out_word
);
  logic            rst_meta, rst_s;
  logic [CFGW-1:0] offset_ns, range_ns;
  logic            q_pass, accept;
  logic [CW-1:0]   q_word;
  logic            vld_d;
  logic [CHW-1:0]  chan_d;
  logic [CW-1:0]   word_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  hwf_cfg u_cfg (
    .clk(clk), .rst_n(rst_s), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .offset_ns(offset_ns), .range_ns(range_ns), .err(cfg_err)
  );

  hwf_quant u_quant (
    .raw(hit_time), .offset_ns(offset_ns), .range_ns(range_ns),
    .res(res_e'(cfg_res)), .both(cfg_both), .edge_in(hit_edge),
    .pass(q_pass), .word(q_word)
  );

  hwf_limit u_limit (
    .clk(clk), .rst_n(rst_s), .start(evt_start), .hit(hit_vld & q_pass),
    .chan(hit_chan), .max_hits(cfg_max_hits), .accept(accept)
  );

  always_comb begin
    vld_d  = accept;
    chan_d = out_chan;
    word_d = out_word;
    if (accept) begin
      chan_d = hit_chan;
      word_d = q_word;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_vld  <= 1'b0;
      out_chan <= '0;
      out_word <= '0;
    end else begin
      out_vld  <= vld_d;
      out_chan <= chan_d;
      out_word <= word_d;
    end
  end
endmodule

// File: rtl/hwf_chk.sv
module hwf_chk
  import hwf_pkg::*;
(
  input logic            clk,
  input logic            rst_s,
  input logic            cfg_err,
  input logic            cfg_both,
  input logic [LIMW-1:0] cfg_max_hits,
  input logic            evt_start,
  input logic            hit_vld,
  input logic [TW-1:0]   hit_time,
  input logic            hit_edge,
  input logic [CFGW-1:0] range_ns,
  input logic            out_vld,
  input logic [CHW-1:0]  out_chan
);
  localparam int NCH = 1 << CHW;
  logic            start_q;
  logic [LIMW:0]   cnt_q [NCH];
  logic [LIMW:0]   nxt;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) start_q <= 1'b0;
    else        start_q <= evt_start;
  end

  always_comb begin
    nxt = start_q ? (LIMW + 1)'(1) : cnt_q[out_chan] + (LIMW + 1)'(1);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) cnt_q[c] <= '0;
      else if (out_vld && out_chan == CHW'(c)) cnt_q[c] <= nxt;
      else if (start_q) cnt_q[c] <= '0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_err |=> cfg_err); // R9
  AST_OUT_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(out_vld) |-> $past(hit_vld)); // R2
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_s)
    hit_vld && ({1'b0, hit_time} >= {(CFGW + 1)'(range_ns) + (CFGW + 1)'(8), 1'b0}) |=> !out_vld); // R4
  AST_LEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    hit_vld && !cfg_both && hit_edge |=> !out_vld); // R8
  AST_LIMIT_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    hit_vld && cfg_max_hits == '0 |=> !out_vld); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_s)
    out_vld |-> nxt <= (LIMW + 1)'(cfg_max_hits)); // R10
endmodule

bind hit_window_filter hwf_chk u_hwf_chk (
  .clk(clk), .rst_s(rst_s), .cfg_err(cfg_err), .cfg_both(cfg_both),
  .cfg_max_hits(cfg_max_hits), .evt_start(evt_start), .hit_vld(hit_vld),
  .hit_time(hit_time), .hit_edge(hit_edge), .range_ns(range_ns),
  .out_vld(out_vld), .out_chan(out_chan)
);

// File: tb/test_hit_window_filter.sv
module test_hit_window_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic [1:0]  cfg_res = '0;
  logic        cfg_both = 1'b0;
  logic [4:0]  cfg_max_hits = 5'd16;
  logic        cfg_err;
  logic        evt_start = 1'b0, hit_vld = 1'b0, hit_edge = 1'b0;
  logic [13:0] hit_time = '0;
  logic [2:0]  hit_chan = '0;
  logic        out_vld;
  logic [2:0]  out_chan;
  logic [9:0]  out_word;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hit_window_filter i_hit_window_filter (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit sel, input int ns);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = 12'(ns);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic start_evt();
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
  endtask

  task automatic hit(input int t, input bit e, input int ch, input bit strt,
                     input bit ev, input int ew, input int ech, input string tag);
    @(negedge clk);
    hit_vld = 1'b1; hit_time = 14'(t); hit_edge = e; hit_chan = 3'(ch); evt_start = strt;
    @(negedge clk);
    hit_vld = 1'b0; evt_start = 1'b0;
    chk({tag, " vld"}, int'(out_vld), int'(ev));
    if (ev) begin
      chk({tag, " word"}, int'(out_word), ew);
      chk({tag, " chan"}, int'(out_chan), ech);
    end
  endtask

  task automatic t_reset();
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    // registers at 0: range 0 keeps raw < 16 ticks, offset 0
    hit(15, 0, 1, 0, 1, 15, 1, "R1 range0 keep");
    hit(16, 0, 1, 0, 0, 0, 0, "R1 range0 drop");
  endtask

  task automatic t_example();
    cfg_res = 2'd2; cfg_both = 1'b1;
    wr_reg(0, 512); wr_reg(1, 1528);
    chk("R9 no err aligned", int'(cfg_err), 0);
    hit(1024, 0, 3, 0, 1, 0, 3, "R3 lower bound");
    hit(1027, 1, 3, 0, 1, 10'h200, 3, "R7 edge bit");
    hit(3068, 0, 4, 0, 1, 511, 4, "R3 top code");
    hit(3071, 1, 4, 0, 1, 10'h3FF, 4, "R7 top trailing");
    hit(3072, 0, 4, 0, 0, 0, 0, "R4 beyond range");
    hit(100, 0, 6, 0, 1, 0, 6, "R6 early hit");
  endtask

  task automatic t_window();
    cfg_res = 2'd3; cfg_both = 1'b0;
    wr_reg(0, 0); wr_reg(1, 1000);
    hit(2015, 0, 0, 0, 1, 251, 0, "R4 last in");
    hit(2016, 0, 0, 0, 0, 0, 0, "R4 first out");
  endtask

  task automatic t_span();
    cfg_res = 2'd0; cfg_both = 1'b0;
    wr_reg(1, 4088);
    hit(1023, 0, 2, 0, 1, 1023, 2, "R5 lead max");
    hit(1024, 0, 2, 0, 0, 0, 0, "R5 lead over");
    cfg_both = 1'b1;
    hit(511, 1, 2, 0, 1, 10'h3FF, 2, "R5 both max");
    hit(512, 0, 2, 0, 0, 0, 0, "R5 both over");
  endtask

  task automatic t_res();
    cfg_both = 1'b0;
    wr_reg(0, 8);
    for (int r = 0; r < 4; r++) begin
      cfg_res = 2'(r);
      hit(53, 0, 5, 0, 1, 37 >> r, 5, "R3 res sweep");
    end
    cfg_res = 2'd0;
    hit(53, 1, 5, 0, 0, 0, 0, "R8 trailing dropped");
  endtask

  task automatic t_align();
    wr_reg(0, 517);
    chk("R9 err set", int'(cfg_err), 1);
    hit(1030, 0, 1, 0, 1, 6, 1, "R9 offset rounded");
    wr_reg(0, 0);
    cfg_res = 2'd3;
    wr_reg(1, 1001);
    hit(2016, 0, 1, 0, 0, 0, 0, "R9 range rounded");
    chk("R9 err sticky", int'(cfg_err), 1);
    cfg_res = 2'd0;
    wr_reg(1, 4088);
  endtask

  task automatic t_limit();
    cfg_max_hits = 5'd3;
    start_evt();
    for (int i = 0; i < 5; i++)
      hit(100, 0, 2, 0, i < 3, 100, 2, "R10 limit");
    hit(100, 0, 5, 0, 1, 100, 5, "R10 other channel");
    hit(200, 0, 2, 1, 1, 200, 2, "R10 start with hit");
    hit(200, 0, 2, 0, 1, 200, 2, "R10 second");
    hit(200, 0, 2, 0, 1, 200, 2, "R10 third");
    hit(200, 0, 2, 0, 0, 0, 0, "R10 fourth dropped");
    cfg_max_hits = 5'd0;
    start_evt();
    hit(100, 0, 7, 0, 0, 0, 0, "R11 zero limit");
    hit(100, 0, 7, 1, 0, 0, 0, "R11 zero limit at start");
  endtask

  task automatic t_latency();
    cfg_max_hits = 5'd16;
    start_evt();
    @(negedge clk);
    hit_vld = 1'b1; hit_time = 14'd40; hit_edge = 1'b0; hit_chan = 3'd3;
    chk("R2 not before edge", int'(out_vld), 0);
    @(negedge clk);
    hit_vld = 1'b0;
    chk("R2 one cycle", int'(out_vld), 1);
    chk("R2 chan", int'(out_chan), 3);
    @(negedge clk);
    chk("R2 single pulse", int'(out_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_example();
    t_window();
    t_span();
    t_res();
    t_align();
    t_limit();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule